// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a slave control port that lets an external controller set up a converter's registers over three wires: an active-low select, a serial clock and a single bidirectional data line. The port and the rest of the block run on one system clock. All three serial inputs pass through a synchronizer, and the port acts on the edges of the serial clock as it sees them in the system clock domain.

Every transaction opens with a 16-bit instruction word. Its flag bit chooses read or write, and its other 15 bits give a register address. Exactly one data byte follows. A write takes effect as soon as the last data bit arrives. On a read, the port drives the data line and launches each bit on a falling edge of the serial clock. A configuration bit selects the bit order, and that order applies to both the instruction and the data.

The tuning word and the phase offset are held in two copies. Writes land in a pending copy. An explicit update command then moves the pending copy into the active copy that drives the outputs.

Top module: `spi3w_ctrl`

## Requirements
- R1: After reset, every register output is zero, the data driver enable is low, and the bit order is MSB-first.
- R2: The instruction is taken from the first 16 rising serial-clock edges after select goes low. In MSB-first order, the first bit is the flag (1 = read) and the next 15 bits are the address, MSB first. A read never modifies a register.
- R3: After the instruction, exactly one data byte is taken, and rising edges beyond the 24th are ignored. There is no address increment.
- R4: A write to address 0x010+k (k < 4) updates byte k of `gen_o` once the 24th rising edge has been seen.
- R5: On a read, the driver enable is high only after the 16th rising edge. Data leaves on falling edges in the selected order, so the controller can sample each bit on the next rising edge. The driver enable stays low for the whole of a write.
- R6: The driver enable drops once select is high.
- R7: Taking select high and then low restarts the instruction phase. A transaction cut short before its 24th edge writes nothing.
- R8: Bit 0 of address 0x000 selects LSB-first order when set. The new order takes effect from the next transaction and applies to both the instruction and the data. In LSB-first order, address bit 0 comes first and the flag comes last.
- R9: Tuning-word bytes live at 0x020+k (k < 4, byte 0 least significant) and phase bytes at 0x028+k (k < 2). Writes to them leave `ftw_o` and `phase_o` unchanged. A read returns the pending value.
- R10: Writing 1 to bit 0 of address 0x030 copies every pending tuning and phase byte into the active outputs. The bit clears itself, so it reads back as 0.
- R11: Unmapped addresses read as 0, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Data line, input side |
| sdio_o | output | 1 | Data line, output side |
| sdio_oe_o | output | 1 | Data line driver enable |
| gen_o | output | 32 | General registers, byte k from address 0x010+k |
| ftw_o | output | 32 | Active tuning word |
| phase_o | output | 16 | Active phase offset |

## Verification
Writes and reads use distinct, asymmetric byte values such as 0xA5, 0x96 and 0x5A, in both bit orders. A reversed shift direction, a wrong bit pick, or the flag taken from the wrong end of the word would therefore show up as a different byte or a different address. Frames of 20 and 32 edges separate the correct byte boundary from an early or late commit, and also expose a missing restart on select. A sequence of shadowed writes, a read-back, the update and a post-update write shows whether the active copy moves only on the update command.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int INSTR_W   = 16;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = INSTR_W - 1;
  localparam int FRAME_LEN = INSTR_W + DATA_W;

  localparam logic [ADDR_W-1:0] A_CFG = 15'h000;
  localparam logic [ADDR_W-1:0] A_GEN = 15'h010;
  localparam logic [ADDR_W-1:0] A_FTW = 15'h020;
  localparam logic [ADDR_W-1:0] A_PH  = 15'h028;
  localparam logic [ADDR_W-1:0] A_UPD = 15'h030;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= {STAGES{RST_VAL}};
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi3w_frame.sv
module spi3w_frame
  import spi3w_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              lsb_first_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] C_INSTR  = CNT_W'(INSTR_W);
  localparam logic [CNT_W-1:0] C_LAST_I = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0] C_END    = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] C_LAST_D = CNT_W'(FRAME_LEN - 1);

  logic               sck_q, rise, fall, in_instr, in_data, rd_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [INSTR_W-1:0] sh_q, sh_nxt;
  logic [DATA_W-1:0]  dat_q, dat_nxt, rbuf_q;
  logic [2:0]         bidx, oidx;

  assign rise     = sck_i & ~sck_q;
  assign fall     = ~sck_i & sck_q;
  assign in_instr = cnt_q < C_INSTR;
  assign in_data  = !in_instr && (cnt_q < C_END);
  assign sh_nxt   = lsb_first_i ? {sdi_i, sh_q[INSTR_W-1:1]} : {sh_q[INSTR_W-2:0], sdi_i};
  assign dat_nxt  = lsb_first_i ? {sdi_i, dat_q[DATA_W-1:1]} : {dat_q[DATA_W-2:0], sdi_i};
  assign bidx     = 3'(cnt_q - C_INSTR);
  assign oidx     = lsb_first_i ? bidx : 3'd7 - bidx;
  assign sdo_oe_o = !cs_n_i && rd_q && !in_instr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      dat_q     <= '0;
      rbuf_q    <= '0;
      rd_q      <= 1'b0;
      addr_o    <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      sdo_o     <= 1'b0;
    end else begin
      sck_q   <= sck_i;
      wr_en_o <= 1'b0;
      if (cs_n_i) begin
        cnt_q <= '0;
        rd_q  <= 1'b0;
      end else begin
        if (rise && cnt_q < C_END) begin
          cnt_q <= cnt_q + 1'b1;
          if (in_instr) begin
            sh_q <= sh_nxt;
            if (cnt_q == C_LAST_I) begin
              rd_q   <= sh_nxt[INSTR_W-1];
              addr_o <= sh_nxt[ADDR_W-1:0];
            end
          end else begin
            dat_q <= dat_nxt;
            if (cnt_q == C_LAST_D && !rd_q) begin
              wr_en_o   <= 1'b1;
              wr_data_o <= dat_nxt;
            end
          end
        end
        // launch read bits on falling edges; capture the byte at the first one
        if (fall && rd_q && in_data) begin
          if (cnt_q == C_INSTR) begin
            rbuf_q <= rd_data_i;
            sdo_o  <= rd_data_i[oidx];
          end else begin
            sdo_o  <= rbuf_q[oidx];
          end
        end
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= C_END);
  p_wr_at_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (cnt_q == C_END) && !rd_q);
  p_oe_after_instr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(cnt_q) >= C_LAST_I);
endmodule

// File: rtl/spi3w_regs.sv
module spi3w_regs
  import spi3w_pkg::*;
#(
  parameter int N_GEN     = 4,
  parameter int FTW_BYTES = 4,
  parameter int PH_BYTES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    lsb_first_o,
  output logic [N_GEN*8-1:0]      gen_o,
  output logic [FTW_BYTES*8-1:0]  ftw_o,
  output logic [PH_BYTES*8-1:0]   ph_o
);
  logic lsb_q, upd_q;
  logic [N_GEN-1:0][7:0]     gen_w;
  logic [FTW_BYTES-1:0][7:0] ftw_pend_w, ftw_act_w;
  logic [PH_BYTES-1:0][7:0]  ph_pend_w, ph_act_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsb_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_CFG) lsb_q <= wr_data_i[0];
      upd_q <= wr_en_i && wr_addr_i == A_UPD && wr_data_i[0];
    end
  end

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_en_i && wr_addr_i == A_GEN + ADDR_W'(g)) q <= wr_data_i;
    end
    assign gen_w[g] = q;
  end

  for (genvar k = 0; k < FTW_BYTES; k++) begin : g_ftw
    logic [7:0] pend_q, act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= '0;
        act_q  <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == A_FTW + ADDR_W'(k)) pend_q <= wr_data_i;
        if (upd_q) act_q <= pend_q;
      end
    end
    assign ftw_pend_w[k] = pend_q;
    assign ftw_act_w[k]  = act_q;
  end

  for (genvar k = 0; k < PH_BYTES; k++) begin : g_ph
    logic [7:0] pend_q, act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= '0;
        act_q  <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == A_PH + ADDR_W'(k)) pend_q <= wr_data_i;
        if (upd_q) act_q <= pend_q;
      end
    end
    assign ph_pend_w[k] = pend_q;
    assign ph_act_w[k]  = act_q;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_CFG) rd_data_o = {7'd0, lsb_q};
    if (rd_addr_i == A_UPD) rd_data_o = {7'd0, upd_q};
    for (int g = 0; g < N_GEN; g++)
      if (rd_addr_i == A_GEN + ADDR_W'(g)) rd_data_o = gen_w[g];
    for (int k = 0; k < FTW_BYTES; k++)
      if (rd_addr_i == A_FTW + ADDR_W'(k)) rd_data_o = ftw_pend_w[k];
    for (int k = 0; k < PH_BYTES; k++)
      if (rd_addr_i == A_PH + ADDR_W'(k)) rd_data_o = ph_pend_w[k];
  end

  assign lsb_first_o = lsb_q;
  assign gen_o       = gen_w;
  assign ftw_o       = ftw_act_w;
  assign ph_o        = ph_act_w;

  p_wr_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i);
  p_upd_selfclear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);
  p_active_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_q |=> $stable(ftw_o) && $stable(ph_o));
endmodule

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int N_GEN       = 4,
  parameter int FTW_BYTES   = 4,
  parameter int PH_BYTES    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   sck_i,
  input  logic                   sdio_i,
  output logic                   sdio_o,
  output logic                   sdio_oe_o,
  output logic [N_GEN*8-1:0]     gen_o,
  output logic [FTW_BYTES*8-1:0] ftw_o,
  output logic [PH_BYTES*8-1:0]  phase_o
);
  logic [2:0]        pins_s;
  logic              lsb_first, wr_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  spi3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, sdio_i}),
    .q_o   (pins_s)
  );

  spi3w_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (pins_s[2]),
    .sck_i      (pins_s[1]),
    .sdi_i      (pins_s[0]),
    .lsb_first_i(lsb_first),
    .rd_data_i  (rd_data),
    .addr_o     (addr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .sdo_o      (sdio_o),
    .sdo_oe_o   (sdio_oe_o)
  );

  spi3w_regs #(.N_GEN(N_GEN), .FTW_BYTES(FTW_BYTES), .PH_BYTES(PH_BYTES)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (addr),
    .rd_data_o  (rd_data),
    .lsb_first_o(lsb_first),
    .gen_o      (gen_o),
    .ftw_o      (ftw_o),
    .ph_o       (phase_o)
  );

  p_oe_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_s[2] |-> !sdio_oe_o);
endmodule

// File: tb/spi3w_ctrl_bench.sv
module spi3w_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic        sdo, oe;
  logic [31:0] gen, ftw;
  logic [15:0] ph;
  int total = 0, bad = 0;

  spi3w_ctrl u_spi3w_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe_o(oe), .gen_o(gen), .ftw_o(ftw), .phase_o(ph)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // nbits edges; bits past 24 are driven as 1
  task automatic xfer(input int nbits, input logic [15:0] ins, input logic [7:0] wd,
                      input logic lsb, output logic [7:0] rd,
                      output logic oe_instr_any, output logic oe_data_all,
                      output logic oe_data_any);
    rd = '0; oe_instr_any = 0; oe_data_all = 1; oe_data_any = 0;
    cs_n = 0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (i < 16)      sdi = lsb ? ins[i] : ins[15-i];
      else if (i < 24) sdi = lsb ? wd[i-16] : wd[23-i];
      else             sdi = 1'b1;
      wait_clk(HALF);
      if (i < 16) oe_instr_any |= oe;
      else begin
        if (i < 24) begin
          if (lsb) rd[i-16] = sdo; else rd[23-i] = sdo;
          oe_data_all &= oe;
        end
        oe_data_any |= oe;
      end
      sck = 1;
      wait_clk(HALF);
      sck = 0;
    end
    wait_clk(HALF);
    cs_n = 1;
    wait_clk(HALF);
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic lsb);
    logic [7:0] r; logic x, y, z;
    xfer(24, {1'b0, a}, d, lsb, r, x, y, z);
  endtask

  task automatic rdb(input logic [14:0] a, input logic lsb, output logic [7:0] r);
    logic x, y, z;
    xfer(24, {1'b1, a}, 8'h00, lsb, r, x, y, z);
  endtask

  task automatic t_reset;
    chk("R1 gen", gen, 32'h0);
    chk("R1 ftw", ftw, 32'h0);
    chk("R1 phase", {16'h0, ph}, 32'h0);
    chk("R1 oe", {31'h0, oe}, 32'h0);
  endtask

  task automatic t_write_read;
    logic [7:0] r; logic oi, oa, od;
    wr(15'h010, 8'hA5, 0);
    chk("R4 gen byte0", gen, 32'h0000_00A5);
    xfer(24, {1'b0, 15'h010}, 8'h3C, 0, r, oi, oa, od);
    chk("R5 no oe in write", {31'h0, oi | od}, 32'h0);
    wr(15'h010, 8'hA5, 0);
    xfer(24, {1'b1, 15'h010}, 8'hFF, 0, r, oi, oa, od);
    chk("R2 read value msb", {24'h0, r}, 32'h0000_00A5);
    chk("R2 read leaves reg", gen, 32'h0000_00A5);
    chk("R5 oe low in instr", {31'h0, oi}, 32'h0);
    chk("R5 oe high in data", {31'h0, oa}, 32'h1);
    chk("R6 oe released", {31'h0, oe}, 32'h0);
  endtask

  task automatic t_extra_edges;
    logic [7:0] r; logic oi, oa, od;
    xfer(32, {1'b0, 15'h012}, 8'h5A, 0, r, oi, oa, od);
    chk("R3 one byte only", gen, 32'h005A_00A5);
  endtask

  task automatic t_abort;
    logic [7:0] r; logic oi, oa, od;
    xfer(20, {1'b0, 15'h010}, 8'hFF, 0, r, oi, oa, od);
    chk("R7 abort no write", gen, 32'h005A_00A5);
    rdb(15'h012, 0, r);
    chk("R7 restart read", {24'h0, r}, 32'h0000_005A);
  endtask

  task automatic t_unmapped;
    logic [7:0] r;
    wr(15'h7FFF, 8'hFF, 0);
    chk("R11 unmapped write", gen, 32'h005A_00A5);
    chk("R11 unmapped no ftw", ftw, 32'h0);
    rdb(15'h7FFF, 0, r);
    chk("R11 unmapped read", {24'h0, r}, 32'h0);
  endtask

  task automatic t_lsb;
    logic [7:0] r;
    wr(15'h000, 8'h01, 0);
    wr(15'h011, 8'h96, 1);
    chk("R8 lsb write", gen, 32'h005A_96A5);
    rdb(15'h012, 1, r);
    chk("R8 lsb read", {24'h0, r}, 32'h0000_005A);
    rdb(15'h000, 1, r);
    chk("R8 cfg readback", {24'h0, r}, 32'h0000_0001);
    wr(15'h000, 8'h00, 1);
    rdb(15'h011, 0, r);
    chk("R8 back to msb", {24'h0, r}, 32'h0000_0096);
  endtask

  task automatic t_shadow;
    logic [7:0] r;
    wr(15'h020, 8'h11, 0);
    wr(15'h021, 8'h22, 0);
    wr(15'h022, 8'h33, 0);
    wr(15'h023, 8'h44, 0);
    wr(15'h028, 8'h55, 0);
    wr(15'h029, 8'h66, 0);
    chk("R9 ftw held", ftw, 32'h0);
    chk("R9 phase held", {16'h0, ph}, 32'h0);
    rdb(15'h021, 0, r);
    chk("R9 pending read", {24'h0, r}, 32'h0000_0022);
    wr(15'h030, 8'h01, 0);
    chk("R10 ftw commit", ftw, 32'h4433_2211);
    chk("R10 phase commit", {16'h0, ph}, 32'h0000_6655);
    rdb(15'h030, 0, r);
    chk("R10 selfclear", {24'h0, r}, 32'h0);
    wr(15'h020, 8'h99, 0);
    chk("R9 hold after commit", ftw, 32'h4433_2211);
  endtask

  initial begin
    wait_clk(4);
    t_reset();
    rst_n = 1;
    wait_clk(4);
    t_write_read();
    t_extra_edges();
    t_abort();
    t_unmapped();
    t_lsb();
    t_shadow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule